// File: doc/BRIEF.md
# User-Mode Base and Limit Address Relocator

This block sits between an execution core and its memory port and turns the addresses a user program issues into physical addresses. Three separate address spaces exist: program, data and stack. Each has a base register and a size register. A user program sees each space as starting at zero and ending just below its size. A user access adds the base of the selected space to the virtual address. The access faults if the virtual address is at or past the size, or if the addition carries out of the address width.

Supervisor accesses skip translation entirely: the physical address equals the virtual address and no check is made. Supervisor software loads the six registers through a write port. A write attempted in user mode changes nothing and raises a privilege fault. Translated results appear one clock after the request by default. The `OUT_REG` parameter can select a combinational output path instead.

Top module: `user_reloc_unit`

## Requirements
- R1: After reset every base and size register is zero, so every user access to spaces 0 to 2 raises a limit fault, and `priv_fault` is low.
- R2: Space code 0 selects the program pair, 1 the data pair and 2 the stack pair. A user access drives `mem_paddr` with base plus virtual address, truncated to `AW` bits.
- R3: A user access whose virtual address is greater than or equal to the selected size raises `lim_fault`, and `mem_valid` stays low.
- R4: A user access whose base plus virtual address carries out of `AW` bits raises `wrap_fault`, and `mem_valid` stays low. `mem_paddr` still shows the truncated sum.
- R5: A supervisor access (`req_super` high) gives `mem_paddr` equal to the virtual address with `mem_valid` high and no fault, for any space code.
- R6: A user access with space code 3 raises `lim_fault`, and `mem_paddr` equals the virtual address.
- R7: A supervisor write with `cfg_sel` = {space[1:0], kind} loads that register (kind 0 = base, 1 = size). Requests from the following cycle on see the new value, while a request in the same cycle sees the old value. A write whose space field is 3 changes nothing and raises no fault.
- R8: A write attempted with `cfg_super` low leaves all six registers unchanged, and `priv_fault` is high for exactly the following cycle.
- R9: With the default `OUT_REG` = 1, results appear one cycle after the request. When `req_valid` was low, `mem_valid`, `lim_fault` and `wrap_fault` are low.
- R10: `mem_valid` is never high together with `lim_fault` or `wrap_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_super | input | 1 | Privilege level of the writer (1 = supervisor) |
| cfg_sel | input | 3 | {space, kind}; kind 0 = base, 1 = size |
| cfg_wdata | input | AW | Write value |
| priv_fault | output | 1 | User-mode write was attempted (one-cycle pulse) |
| req_valid | input | 1 | Access request strobe |
| req_super | input | 1 | Privilege level of the access (1 = supervisor) |
| req_space | input | 2 | 0 program, 1 data, 2 stack, 3 none |
| req_vaddr | input | AW | Virtual address |
| mem_valid | output | 1 | Translated access may proceed |
| mem_paddr | output | AW | Physical address |
| lim_fault | output | 1 | Virtual address outside the space size |
| wrap_fault | output | 1 | Relocation carried out of the address width |

## Verification
Embedded properties check on every cycle that an access never both proceeds and faults, and that supervisor accesses come out unrelocated one cycle later. They also check that idle cycles produce no result, and that a user-mode write leaves every register stable and pulses the privilege fault. They further check that supervisor writes land in the addressed register. Only the bench scenarios show the actual relocation sums and the limit boundary at size and size minus one. The same holds for the carry at the top of the address range, the treatment of the unused space code, and the ordering of a write against a request in the same cycle.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

   localparam int NUM_SPACES = 3;

   typedef enum logic [1:0] {
      SPC_PROG  = 2'd0,
      SPC_DATA  = 2'd1,
      SPC_STACK = 2'd2,
      SPC_NONE  = 2'd3
   } space_e;

   localparam logic KIND_BASE = 1'b0;
   localparam logic KIND_SIZE = 1'b1;

   function automatic logic space_is_real(input logic [1:0] s);
      return (s != SPC_NONE);
   endfunction

endpackage

// File: rtl/reloc_regfile.sv
module reloc_regfile
   import reloc_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic                            cfg_super,
   input  logic [2:0]                      cfg_sel,
   input  logic [AW-1:0]                   cfg_wdata,
   output logic [NUM_SPACES-1:0][AW-1:0]   base_o,
   output logic [NUM_SPACES-1:0][AW-1:0]   size_o,
   output logic                            priv_fault_o
);

   logic [1:0] sel_space;
   logic       sel_kind;
   logic       wr_ok;
   logic       wr_bad;

   assign sel_space = cfg_sel[2:1];
   assign sel_kind  = cfg_sel[0];
   assign wr_ok     = cfg_we && cfg_super && space_is_real(sel_space);
   assign wr_bad    = cfg_we && !cfg_super;

   logic [NUM_SPACES-1:0][AW-1:0] base_q;
   logic [NUM_SPACES-1:0][AW-1:0] size_q;

   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_pair
      logic hit;
      assign hit = wr_ok && (sel_space == s[1:0]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[s] <= '0;
            size_q[s] <= '0;
         end else if (hit) begin
            if (sel_kind == KIND_BASE) base_q[s] <= cfg_wdata;
            else                       size_q[s] <= cfg_wdata;
         end
      end

      // R7
      base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_super && cfg_sel == {s[1:0], KIND_BASE})
         |=> base_q[s] == $past(cfg_wdata));

      // R7
      size_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_super && cfg_sel == {s[1:0], KIND_SIZE})
         |=> size_q[s] == $past(cfg_wdata));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) priv_fault_o <= 1'b0;
      else        priv_fault_o <= wr_bad;
   end

   assign base_o = base_q;
   assign size_o = size_q;

   // R8
   user_write_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_super) |=> ($stable(base_q) && $stable(size_q) && priv_fault_o));

   // R8
   priv_pulse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && !cfg_super) |=> !priv_fault_o);

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
   import reloc_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [NUM_SPACES-1:0][AW-1:0]   base_i,
   input  logic [NUM_SPACES-1:0][AW-1:0]   size_i,
   input  logic                            req_valid,
   input  logic                            req_super,
   input  logic [1:0]                      req_space,
   input  logic [AW-1:0]                   req_vaddr,
   output logic                            x_valid,
   output logic [AW-1:0]                   x_paddr,
   output logic                            x_lim,
   output logic                            x_wrap
);

   localparam int SW = AW + 1;

   logic [AW-1:0] base_sel;
   logic [AW-1:0] size_sel;
   logic          real_space;
   logic [SW-1:0] sum;
   logic          over_lim;
   logic          carry;

   always_comb begin
      base_sel = '0;
      size_sel = '0;
      for (int s = 0; s < NUM_SPACES; s++) begin
         if (req_space == s[1:0]) begin
            base_sel = base_i[s];
            size_sel = size_i[s];
         end
      end
   end

   assign real_space = space_is_real(req_space);
   assign sum        = {1'b0, base_sel} + {1'b0, req_vaddr};
   assign carry      = sum[SW-1];
   assign over_lim   = !real_space || (req_vaddr >= size_sel);

   always_comb begin
      x_valid = 1'b0;
      x_paddr = req_vaddr;
      x_lim   = 1'b0;
      x_wrap  = 1'b0;
      if (req_valid) begin
         if (req_super) begin
            x_valid = 1'b1;
         end else begin
            x_paddr = sum[AW-1:0];
            x_lim   = over_lim;
            x_wrap  = carry;
            x_valid = !over_lim && !carry;
         end
      end
   end

endmodule

// File: rtl/reloc_outstage.sv
module reloc_outstage #(
   parameter int AW      = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          x_valid,
   input  logic [AW-1:0] x_paddr,
   input  logic          x_lim,
   input  logic          x_wrap,
   output logic          mem_valid,
   output logic [AW-1:0] mem_paddr,
   output logic          lim_fault,
   output logic          wrap_fault
);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_valid  <= 1'b0;
            mem_paddr  <= '0;
            lim_fault  <= 1'b0;
            wrap_fault <= 1'b0;
         end else begin
            mem_valid  <= x_valid;
            mem_paddr  <= x_paddr;
            lim_fault  <= x_lim;
            wrap_fault <= x_wrap;
         end
      end
   end else begin : g_comb
      assign mem_valid  = x_valid;
      assign mem_paddr  = x_paddr;
      assign lim_fault  = x_lim;
      assign wrap_fault = x_wrap;
   end

endmodule

// File: rtl/user_reloc_unit.sv
module user_reloc_unit
   import reloc_pkg::*;
#(
   parameter int AW      = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_super,
   input  logic [2:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   output logic          priv_fault,
   input  logic          req_valid,
   input  logic          req_super,
   input  logic [1:0]    req_space,
   input  logic [AW-1:0] req_vaddr,
   output logic          mem_valid,
   output logic [AW-1:0] mem_paddr,
   output logic          lim_fault,
   output logic          wrap_fault
);

   if (AW < 2 || AW > 32) begin : g_bad_aw
      $error("user_reloc_unit: AW must lie in 2..32");
   end

   logic [NUM_SPACES-1:0][AW-1:0] base_w;
   logic [NUM_SPACES-1:0][AW-1:0] size_w;
   logic                          x_valid;
   logic [AW-1:0]                 x_paddr;
   logic                          x_lim;
   logic                          x_wrap;

   reloc_regfile #(.AW(AW)) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_super    (cfg_super),
      .cfg_sel      (cfg_sel),
      .cfg_wdata    (cfg_wdata),
      .base_o       (base_w),
      .size_o       (size_w),
      .priv_fault_o (priv_fault)
   );

   reloc_xlate #(.AW(AW)) i_xlate (
      .base_i    (base_w),
      .size_i    (size_w),
      .req_valid (req_valid),
      .req_super (req_super),
      .req_space (req_space),
      .req_vaddr (req_vaddr),
      .x_valid   (x_valid),
      .x_paddr   (x_paddr),
      .x_lim     (x_lim),
      .x_wrap    (x_wrap)
   );

   reloc_outstage #(.AW(AW), .OUT_REG(OUT_REG)) i_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .x_valid    (x_valid),
      .x_paddr    (x_paddr),
      .x_lim      (x_lim),
      .x_wrap     (x_wrap),
      .mem_valid  (mem_valid),
      .mem_paddr  (mem_paddr),
      .lim_fault  (lim_fault),
      .wrap_fault (wrap_fault)
   );

   // R10
   no_grant_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (!lim_fault && !wrap_fault));

   if (OUT_REG) begin : g_seq_chk
      // R5
      super_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_super) |=>
         (mem_valid && !lim_fault && !wrap_fault && mem_paddr == $past(req_vaddr)));

      // R9
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> (!mem_valid && !lim_fault && !wrap_fault));
   end

endmodule

// File: tb/test_user_reloc_unit.sv
module test_user_reloc_unit;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_super = 1'b0;
   logic [2:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          priv_fault;
   logic          req_valid = 1'b0;
   logic          req_super = 1'b0;
   logic [1:0]    req_space = '0;
   logic [AW-1:0] req_vaddr = '0;
   logic          mem_valid;
   logic [AW-1:0] mem_paddr;
   logic          lim_fault;
   logic          wrap_fault;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   user_reloc_unit #(.AW(AW)) i_user_reloc_unit (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_super(cfg_super), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .priv_fault(priv_fault),
      .req_valid(req_valid), .req_super(req_super), .req_space(req_space),
      .req_vaddr(req_vaddr), .mem_valid(mem_valid), .mem_paddr(mem_paddr),
      .lim_fault(lim_fault), .wrap_fault(wrap_fault)
   );

   // vector: [37] super, [36:35] space, [34:19] vaddr,
   //         [18] valid, [17:2] paddr, [1] lim, [0] wrap
   localparam int NV = 12;
   localparam logic [37:0] VEC [NV] = '{
      {1'b0, 2'd0, 16'h0000, 1'b1, 16'h1000, 1'b0, 1'b0},   // R2 program
      {1'b0, 2'd0, 16'h07FF, 1'b1, 16'h17FF, 1'b0, 1'b0},   // R3 size-1
      {1'b0, 2'd0, 16'h0800, 1'b0, 16'h1800, 1'b1, 1'b0},   // R3 at size
      {1'b0, 2'd1, 16'h1234, 1'b1, 16'h5234, 1'b0, 1'b0},   // R2 data
      {1'b0, 2'd1, 16'h2000, 1'b0, 16'h6000, 1'b1, 1'b0},   // R3 data
      {1'b0, 2'd2, 16'h0FFF, 1'b1, 16'hFFFF, 1'b0, 1'b0},   // R4 top edge
      {1'b0, 2'd2, 16'h1000, 1'b0, 16'h0000, 1'b0, 1'b1},   // R4 carry
      {1'b0, 2'd2, 16'h2000, 1'b0, 16'h1000, 1'b1, 1'b1},   // R3 R4 both
      {1'b1, 2'd1, 16'hABCD, 1'b1, 16'hABCD, 1'b0, 1'b0},   // R5
      {1'b1, 2'd2, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0, 1'b0},   // R5
      {1'b0, 2'd3, 16'h0040, 1'b0, 16'h0040, 1'b1, 1'b0},   // R6
      {1'b1, 2'd3, 16'h0040, 1'b1, 16'h0040, 1'b0, 1'b0}    // R5 code 3
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_out(input string req, input logic v, input logic [AW-1:0] pa,
                            input logic lf, input logic wf);
      chk({req, " mem_valid"}, 32'(mem_valid), 32'(v));
      chk({req, " mem_paddr"}, 32'(mem_paddr), 32'(pa));
      chk({req, " lim_fault"}, 32'(lim_fault), 32'(lf));
      chk({req, " wrap_fault"}, 32'(wrap_fault), 32'(wf));
   endtask

   task automatic wr(input logic sup, input logic [2:0] sel, input logic [AW-1:0] d);
      cfg_we = 1'b1; cfg_super = sup; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_super = 1'b0;
   endtask

   task automatic rq(input logic sup, input logic [1:0] sp, input logic [AW-1:0] va);
      req_valid = 1'b1; req_super = sup; req_space = sp; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_out("R1 idle", 1'b0, 16'h0000, 1'b0, 1'b0);
      chk("R1 priv_fault", 32'(priv_fault), 32'h0);
      rq(1'b0, 2'd0, 16'h0000);
      check_out("R1 prog size zero", 1'b0, 16'h0000, 1'b1, 1'b0);
      rq(1'b0, 2'd2, 16'h0000);
      check_out("R1 stack size zero", 1'b0, 16'h0000, 1'b1, 1'b0);

      // R7 supervisor setup
      wr(1'b1, 3'b000, 16'h1000);
      wr(1'b1, 3'b001, 16'h0800);
      wr(1'b1, 3'b010, 16'h4000);
      wr(1'b1, 3'b011, 16'h2000);
      wr(1'b1, 3'b100, 16'hF000);
      wr(1'b1, 3'b101, 16'h2000);
      chk("R7 no priv fault", 32'(priv_fault), 32'h0);

      for (int i = 0; i < NV; i++) begin
         rq(VEC[i][37], VEC[i][36:35], VEC[i][34:19]);
         check_out($sformatf("vec%0d R2-table", i), VEC[i][18], VEC[i][17:2],
                   VEC[i][1], VEC[i][0]);
      end

      // R8 user write ignored
      wr(1'b0, 3'b010, 16'h9999);
      chk("R8 priv pulse", 32'(priv_fault), 32'h1);
      rq(1'b0, 2'd1, 16'h0010);
      chk("R8 pulse ends", 32'(priv_fault), 32'h0);
      check_out("R8 data base kept", 1'b1, 16'h4010, 1'b0, 1'b0);

      // R7 space code 3 write ignored
      wr(1'b1, 3'b110, 16'h1234);
      chk("R7 code3 no fault", 32'(priv_fault), 32'h0);
      rq(1'b0, 2'd3, 16'h0001);
      check_out("R7 code3 no effect", 1'b0, 16'h0001, 1'b1, 1'b0);

      // R7 write and request in same cycle
      cfg_we = 1'b1; cfg_super = 1'b1; cfg_sel = 3'b001; cfg_wdata = 16'h0010;
      req_valid = 1'b1; req_super = 1'b0; req_space = 2'd0; req_vaddr = 16'h0100;
      @(negedge clk);
      cfg_we = 1'b0;
      check_out("R7 same cycle old size", 1'b1, 16'h1100, 1'b0, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      check_out("R7 next cycle new size", 1'b0, 16'h1100, 1'b1, 1'b0);

      // R9 idle request produces nothing
      req_vaddr = 16'hFFFF; req_space = 2'd2;
      @(negedge clk);
      check_out("R9 idle", 1'b0, 16'hFFFF, 1'b0, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule